// File: doc/BRIEF.md
# Cascadable 2x2 Multiply-Add Array

This block is an unsigned parallel multiplier assembled from one repeated arithmetic cell. Each cell takes a 2-bit multiplicand digit, a 2-bit multiplier digit and two 2-bit addend digits. It returns a 4-bit result split into a low digit and a high digit. The sum always fits: 3*3 + 3 + 3 = 15. A generator tiles the cells into an M_BITS by N_BITS grid. The addend inputs of each cell carry the digits of its neighbours, so no adders or other logic sit between cells.

The grid has two free addend words. One word, as wide as the multiplicand, enters along the first row. The other word, as wide as the multiplier, enters along the first column. The whole array therefore returns X*Y + A + B in a single combinational pass. The width of the result is M_BITS+N_BITS, and that width holds even the largest possible sum. An optional register stage with a synchronous reset can capture the result for timing closure. It is enabled by default.

Top module: `pmul_top`

## Requirements
- R1: A single-cell array (M_BITS = N_BITS = 2) returns x*y + ax + ay in 4 bits for all 256 input combinations. For example, x=2, y=3, ax=1, ay=2 gives 9.
- R2: A 4x4 array returns x*y + ax + ay exactly, for every one of the 65536 input combinations.
- R3: An 8x8 array returns x*y + ax + ay for random operands and for corner values. With x=0 the result equals ax + ay.
- R4: The result never overflows its width. With all inputs at all ones, the result is 2^(M_BITS+N_BITS) - 1, all bits set.
- R5: With both addend words at zero, the result is the plain unsigned product x*y.
- R6: With REG_OUT=1, s_out shows the result of the inputs present at a rising clock edge one edge later. A change of input between edges does not move s_out.
- R7: While rst is high at a rising edge, s_out becomes 0 whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset of the output register |
| x_in | input | M_BITS | Unsigned multiplicand |
| y_in | input | N_BITS | Unsigned multiplier |
| ax_in | input | M_BITS | Addend word entering along the first row of cells |
| ay_in | input | N_BITS | Addend word entering along the first column of cells |
| s_out | output | M_BITS+N_BITS | x_in*y_in + ax_in + ay_in, registered when REG_OUT=1 |

## Verification
The array holds no state. A miswired cascade link or a wrong cell gate therefore shows as a wrong s_out value for exactly those input patterns that set the faulty digit, one clock after those inputs are applied. The sweep of every input pattern on the 4x4 and 2x2 arrays covers every digit path. All-ones operands and addends exercise the longest ripple, which ends in the top result digit. A fault in the output register shows up as a one-cycle shift of the whole result sequence, or as a non-zero value after reset.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  typedef logic [1:0] digit_t;

  // one-bit full adder, returns {carry, sum}
  function automatic logic [1:0] full_add(input logic a, input logic b, input logic c);
    full_add = {(a & b) | (a & c) | (b & c), a ^ b ^ c};
  endfunction

endpackage

// File: rtl/pmul_cell.sv
module pmul_cell
  import pmul_pkg::*;
(
  input  digit_t x,
  input  digit_t y,
  input  digit_t k,
  input  digit_t m,
  output digit_t lo,
  output digit_t hi
);

  logic [3:0] p;
  logic [3:0] kk;
  logic [3:0] mm;
  logic [3:0] t;
  logic [3:0] u;
  logic [3:0] ct;
  logic [3:0] cu;
  logic       pa;
  logic       pb;
  logic       pc;
  logic       pd;

  // 2x2 partial-product gates
  always_comb begin
    pa   = x[1] & y[0];
    pb   = x[0] & y[1];
    pd   = x[1] & y[1];
    pc   = pa & pb;
    p[0] = x[0] & y[0];
    p[1] = pa ^ pb;
    p[2] = pd ^ pc;
    p[3] = pd & pc;
  end

  // two ripple additions; the top bit cannot carry out (max 15)
  always_comb begin
    kk    = {2'b00, k};
    mm    = {2'b00, m};
    ct[0] = 1'b0;
    cu[0] = 1'b0;
    for (int i = 0; i < 3; i++) begin
      {ct[i+1], t[i]} = full_add(p[i], kk[i], ct[i]);
    end
    t[3] = p[3] ^ kk[3] ^ ct[3];
    for (int i = 0; i < 3; i++) begin
      {cu[i+1], u[i]} = full_add(t[i], mm[i], cu[i]);
    end
    u[3] = t[3] ^ mm[3] ^ cu[3];
  end

  assign lo = u[1:0];
  assign hi = u[3:2];

endmodule

// File: rtl/pmul_grid.sv
module pmul_grid
  import pmul_pkg::*;
#(
  parameter int M_BITS = 8,
  parameter int N_BITS = 8
) (
  input  logic [M_BITS-1:0]        x,
  input  logic [N_BITS-1:0]        y,
  input  logic [M_BITS-1:0]        ax,
  input  logic [N_BITS-1:0]        ay,
  output logic [M_BITS+N_BITS-1:0] s
);

  localparam int NX = M_BITS / 2;
  localparam int NY = N_BITS / 2;

  digit_t lo_w [NY][NX];
  digit_t hi_w [NY][NX];
  digit_t k_w  [NY][NX];
  digit_t m_w  [NY][NX];

  for (genvar j = 0; j < NY; j++) begin : g_row
    for (genvar i = 0; i < NX; i++) begin : g_col
      // k input: external word on the first row, else the digit from the row above
      if (j == 0) begin : g_k_ext
        assign k_w[j][i] = ax[2*i+1:2*i];
      end else if (i == NX-1) begin : g_k_top
        assign k_w[j][i] = hi_w[j-1][NX-1];
      end else begin : g_k_up
        assign k_w[j][i] = lo_w[j-1][i+1];
      end
      // m input: external word on the first column, else carry from the left neighbour
      if (i == 0) begin : g_m_ext
        assign m_w[j][i] = ay[2*j+1:2*j];
      end else begin : g_m_rip
        assign m_w[j][i] = hi_w[j][i-1];
      end

      pmul_cell u_cell (
        .x  (x[2*i+1:2*i]),
        .y  (y[2*j+1:2*j]),
        .k  (k_w[j][i]),
        .m  (m_w[j][i]),
        .lo (lo_w[j][i]),
        .hi (hi_w[j][i])
      );
    end
  end

  // result digits: one per row from column 0, then the last row, then its final carry
  for (genvar j = 0; j < NY; j++) begin : g_out_row
    assign s[2*j+1:2*j] = lo_w[j][0];
  end
  for (genvar i = 1; i < NX; i++) begin : g_out_col
    assign s[2*(NY+i)-1:2*(NY+i-1)] = lo_w[NY-1][i];
  end
  assign s[M_BITS+N_BITS-1:M_BITS+N_BITS-2] = hi_w[NY-1][NX-1];

endmodule

// File: rtl/pmul_oreg.sv
module pmul_oreg #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end
  end else begin : g_wire
    assign q = d;
  end

endmodule

// File: rtl/pmul_top.sv
module pmul_top #(
  parameter int M_BITS  = 8,
  parameter int N_BITS  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [M_BITS-1:0]        x_in,
  input  logic [N_BITS-1:0]        y_in,
  input  logic [M_BITS-1:0]        ax_in,
  input  logic [N_BITS-1:0]        ay_in,
  output logic [M_BITS+N_BITS-1:0] s_out
);

  localparam int W = M_BITS + N_BITS;

  logic [W-1:0] sum_w;

  pmul_grid #(.M_BITS(M_BITS), .N_BITS(N_BITS)) u_grid (
    .x  (x_in),
    .y  (y_in),
    .ax (ax_in),
    .ay (ay_in),
    .s  (sum_w)
  );

  pmul_oreg #(.W(W), .REG_OUT(REG_OUT)) u_oreg (
    .clk (clk),
    .rst (rst),
    .d   (sum_w),
    .q   (s_out)
  );

  // arithmetic reference for the checks below
  logic [W-1:0] ref_w;
  assign ref_w = W'(x_in) * W'(y_in) + W'(ax_in) + W'(ay_in);

  if (REG_OUT) begin : g_chk_reg
    // R2/R3/R4: registered result equals the arithmetic sum of the prior inputs
    a_r2_sum_matches: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> s_out == $past(ref_w));
    // R5: zero addends give the bare product
    a_r5_product_only: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ax_in == '0 && ay_in == '0))
        |-> s_out == $past(W'(x_in) * W'(y_in)));
    // R3: zero multiplicand leaves only the addends
    a_r3_zero_operand: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(x_in == '0))
        |-> s_out == $past(W'(ax_in) + W'(ay_in)));
    // R6: inputs held across an edge keep the output steady one edge later
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $stable(x_in) && $stable(y_in) && $stable(ax_in) && $stable(ay_in))
        |=> $stable(s_out));
  end else begin : g_chk_comb
    a_r2_sum_comb: assert property (@(posedge clk) disable iff (rst)
      s_out == ref_w);
    a_r5_product_comb: assert property (@(posedge clk) disable iff (rst)
      (ax_in == '0 && ay_in == '0) |-> s_out == W'(x_in) * W'(y_in));
    a_r3_zero_comb: assert property (@(posedge clk) disable iff (rst)
      (x_in == '0) |-> s_out == W'(ax_in) + W'(ay_in));
    a_r4_fits_comb: assert property (@(posedge clk) disable iff (rst)
      (&x_in && &y_in && &ax_in && &ay_in) |-> &s_out);
  end

endmodule

// File: tb/pmul_top_test.sv
module pmul_top_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  bx, by, bax, bay;
  logic [15:0] bs;
  logic [3:0]  sx, sy, sax, say;
  logic [7:0]  ss;
  logic [1:0]  cx, cy, cax, cay;
  logic [3:0]  cs;

  pmul_top #(.M_BITS(8), .N_BITS(8)) uut (
    .clk(clk), .rst(rst), .x_in(bx), .y_in(by), .ax_in(bax), .ay_in(bay), .s_out(bs));
  pmul_top #(.M_BITS(4), .N_BITS(4)) uut_small (
    .clk(clk), .rst(rst), .x_in(sx), .y_in(sy), .ax_in(sax), .ay_in(say), .s_out(ss));
  pmul_top #(.M_BITS(2), .N_BITS(2)) uut_cell (
    .clk(clk), .rst(rst), .x_in(cx), .y_in(cy), .ax_in(cax), .ay_in(cay), .s_out(cs));

  int checks = 0;
  int errors = 0;
  int last_big = 0;

  int    q_big[$];
  string t_big[$];
  int    q_small[$];
  int    q_cell[$];
  string t_cell[$];

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic compare_all();
    if (q_big.size() > 0) begin
      last_big = q_big.pop_front();
      check(t_big.pop_front(), int'(bs), last_big);
    end
    if (q_small.size() > 0) check("R2 4x4 sweep", int'(ss), q_small.pop_front());
    if (q_cell.size() > 0)  check(t_cell.pop_front(), int'(cs), q_cell.pop_front());
  endtask

  task automatic drive(input int n);
    string tag;
    // 4x4: every combination, R2
    {say, sax, sy, sx} = n[15:0];
    q_small.push_back(int'(sx) * int'(sy) + int'(sax) + int'(say));
    // 2x2 cell: all 256 patterns repeated, R1
    {cay, cax, cy, cx} = n[7:0];
    q_cell.push_back(int'(cx) * int'(cy) + int'(cax) + int'(cay));
    if (cx == 2'd2 && cy == 2'd3 && cax == 2'd1 && cay == 2'd2) t_cell.push_back("R1 example 2*3+1+2");
    else t_cell.push_back("R1 cell");
    // 8x8: directed corners then random, R3
    case (n)
      0: begin bx = 8'hFF; by = 8'hFF; bax = 8'hFF; bay = 8'hFF; tag = "R4 all ones"; end
      1: begin bx = 8'd173; by = 8'd219; bax = 8'd0; bay = 8'd0; tag = "R5 product"; end
      2: begin bx = 8'hFF; by = 8'hFF; bax = 8'd0; bay = 8'd0; tag = "R5 max product"; end
      3: begin bx = 8'd0; by = 8'hFF; bax = 8'hFF; bay = 8'hFF; tag = "R3 zero x"; end
      4: begin bx = 8'hFF; by = 8'd0; bax = 8'hFF; bay = 8'd0; tag = "R3 zero y"; end
      5: begin bx = 8'd1; by = 8'hFF; bax = 8'hFF; bay = 8'hFF; tag = "R3 unit x"; end
      default: begin
        bx = 8'($urandom); by = 8'($urandom); bax = 8'($urandom); bay = 8'($urandom);
        tag = "R3 random";
      end
    endcase
    q_big.push_back(int'(bx) * int'(by) + int'(bax) + int'(bay));
    t_big.push_back(tag);
  endtask

  initial begin
    bx = '0; by = '0; bax = '0; bay = '0;
    sx = '0; sy = '0; sax = '0; say = '0;
    cx = '0; cy = '0; cax = '0; cay = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 reset 8x8", int'(bs), 0);
    check("R7 reset 4x4", int'(ss), 0);
    check("R7 reset 2x2", int'(cs), 0);
    rst = 1'b0;
    for (int n = 0; n < 65536; n++) begin
      @(negedge clk);
      compare_all();
      drive(n);
    end
    @(negedge clk);
    compare_all();
    // R6: output moves only at the edge
    bx = 8'd3; by = 8'd5; bax = 8'd7; bay = 8'd11;
    #1;
    check("R6 no change before edge", int'(bs), last_big);
    @(posedge clk);
    #1;
    check("R6 one edge latency", int'(bs), 3*5 + 7 + 11);
    // R7: reset with busy inputs
    @(negedge clk);
    bx = 8'hFF; by = 8'hFF; bax = 8'hFF; bay = 8'hFF;
    sx = 4'hF; sy = 4'hF; sax = 4'hF; say = 4'hF;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R7 reset clears 8x8", int'(bs), 0);
    check("R7 reset clears 4x4", int'(ss), 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R4 all ones after reset", int'(bs), 65535);
    check("R4 all ones 4x4", int'(ss), 255);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule